// File: doc/BRIEF.md
# DMA Channel Request Gate

This block keeps one pending-request flag for each of several DMA channels and decides which channels may present that flag to the transfer engine. Each channel selects exactly one trigger from a shared pool: peripheral request lines, a per-channel software pulse, and external interrupt pins. A rising edge on the chosen trigger, or a software pulse when software is chosen, sets the channel's flag.

A two-bit transfer mode per channel gates the flag. Codes 01 and 11 let it through. Codes 00 and 10 block it, and in those codes the flag is actively cleared rather than kept. A one-cycle configuration write port loads the mode and source fields of one channel.

Each channel hands its request to the engine over a valid/ready pair. `req_valid[i]` stays high until the engine raises `req_ready[i]` in the same cycle, and that handshake starts service. The engine may hold ready low for as long as it needs, and the request waits without loss. Ready with no valid has no effect. A new trigger that arrives in the cycle of the handshake keeps the request alive, so that trigger is not dropped.

Top module: `dma_req_gate`

## Requirements
- R1: After reset every channel's mode is 00 and its source code is 0, and `req_valid` is all zero. Triggers fired before any configuration write produce no request.
- R2: Source codes 0 to NUM_PERIPH-1 select `periph_req[code]`. A 0-to-1 change on that line, sampled at a clock edge, makes `req_valid` rise right after that edge. A line held high does not set the flag again.
- R3: Source codes NUM_PERIPH+1 upward select `ext_irq[code-NUM_PERIPH-1]`. Each pin passes through two synchronizer flops before edge detection, so a rise first seen at edge n shows on `req_valid` after edge n+2. A falling edge has no effect.
- R4: Source code NUM_PERIPH selects the software trigger. A high cycle on `sw_set[i]` sets channel i's flag at that edge, with no edge detection.
- R5: Only the selected trigger sets a channel's flag. Codes at or above NUM_PERIPH+1+NUM_EXT select nothing.
- R6: `req_valid[i]` can be high only while the mode of channel i is 01 or 11. In either active code, every new trigger yields a new request.
- R7: While the mode is 00 or 10, the flag is cleared at every edge, so triggers arriving then are lost. A pending request dropped by such a mode does not come back when an active code is written again.
- R8: Once high, `req_valid[i]` stays high until a cycle with `req_ready[i]` high. It is low after that edge unless R9 applies.
- R9: A set event in the same cycle as the handshake wins, and `req_valid[i]` remains high.
- R10: `req_ready[i]` while `req_valid[i]` is low changes nothing, and does not block a set in that cycle.
- R11: A configuration write (with `cfg_we` high) updates only channel `cfg_ch`. Several channels may select the same trigger and are all set by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req | input | NUM_PERIPH | Peripheral request lines, synchronous |
| ext_irq | input | NUM_EXT | External interrupt pins, asynchronous |
| sw_set | input | NUM_CH | Software trigger pulse per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_mode | input | 2 | Transfer mode code to load |
| cfg_sel | input | SEL_W | Source code to load |
| req_valid | output | NUM_CH | Request offered to the transfer engine |
| req_ready | input | NUM_CH | Engine accepts the request (handshake) |

## Verification
The bench sweeps every channel, every mode code, every source code (including the unused top codes) and every trigger, and expects a request only where the selected code matches the fired trigger under an odd mode. A mux decode off by one, or a gate that trusts bit 1 of the mode, fails there. Directed cases cover the other corners. A request dropped by mode 10 must not reappear, since a design that only masks the output would bring it back. A set in the handshake cycle must survive, since ack priority would lose it. A held peripheral level must not fire again, and external pins must honour the exact two-flop delay.

// File: rtl/dma_req_gate_pkg.sv
package dma_req_gate_pkg;

  typedef enum logic [1:0] {
    XMODE_OFF    = 2'b00,
    XMODE_SINGLE = 2'b01,
    XMODE_RSVD   = 2'b10,
    XMODE_REPEAT = 2'b11
  } xfer_mode_e;

  // Odd codes are the enabled ones; 00 and 10 both block and discard.
  function automatic logic mode_enabled(input xfer_mode_e m);
    return (m == XMODE_SINGLE) || (m == XMODE_REPEAT);
  endfunction

endpackage

// File: rtl/dma_req_edge.sv
module dma_req_edge #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);

  logic [W-1:0] synced;
  logic [W-1:0] prev_q;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [W-1:0] stage_q [SYNC_STAGES];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      end else begin
        stage_q[0] <= din;
        for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
    end
    assign synced = stage_q[SYNC_STAGES-1];
  end else begin : g_direct
    assign synced = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= synced;
  end

  assign rise = synced & ~prev_q;

endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
  import dma_req_gate_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_hit,
  input  logic [1:0]         cfg_mode,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               ready,
  output logic               valid,
  output logic               active,
  output logic               set_evt
);

  xfer_mode_e       mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             pend_q;
  logic             hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XMODE_OFF;
      sel_q  <= '0;
    end else if (cfg_hit) begin
      mode_q <= xfer_mode_e'(cfg_mode);
      sel_q  <= cfg_sel;
    end
  end

  // Source select: codes past the last source match nothing.
  always_comb begin
    set_evt = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_q == SEL_W'(k)) set_evt = src_evt[k];
    end
  end

  assign active = mode_enabled(mode_q);
  assign hs     = valid & ready;

  // Disabled modes flush the flag; a new set outranks the handshake.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= active & (set_evt | (pend_q & ~hs));
  end

  assign valid = pend_q & active;

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_req_gate_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_PERIPH = 8,
  parameter int NUM_EXT    = 2,
  parameter int CH_W       = $clog2(NUM_CH),
  parameter int SEL_W      = $clog2(NUM_PERIPH + 1 + NUM_EXT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [NUM_EXT-1:0]    ext_irq,
  input  logic [NUM_CH-1:0]     sw_set,
  input  logic                  cfg_we,
  input  logic [CH_W-1:0]       cfg_ch,
  input  logic [1:0]            cfg_mode,
  input  logic [SEL_W-1:0]      cfg_sel,
  output logic [NUM_CH-1:0]     req_valid,
  input  logic [NUM_CH-1:0]     req_ready
);

  localparam int NUM_SRC = NUM_PERIPH + 1 + NUM_EXT;

  logic [NUM_PERIPH-1:0] periph_rise;
  logic [NUM_EXT-1:0]    ext_rise;
  logic [NUM_CH-1:0]     ch_active;
  logic [NUM_CH-1:0]     set_evt;

  dma_req_edge #(.W(NUM_PERIPH), .SYNC_STAGES(0)) u_periph_edge (
    .clk(clk), .rst_n(rst_n), .din(periph_req), .rise(periph_rise)
  );

  dma_req_edge #(.W(NUM_EXT), .SYNC_STAGES(2)) u_ext_edge (
    .clk(clk), .rst_n(rst_n), .din(ext_irq), .rise(ext_rise)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [NUM_SRC-1:0] src_evt;
    logic               cfg_hit;

    assign src_evt = {ext_rise, sw_set[i], periph_rise};
    assign cfg_hit = cfg_we && (cfg_ch == CH_W'(i));

    dma_req_chan #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_hit (cfg_hit),
      .cfg_mode(cfg_mode),
      .cfg_sel (cfg_sel),
      .src_evt (src_evt),
      .ready   (req_ready[i]),
      .valid   (req_valid[i]),
      .active  (ch_active[i]),
      .set_evt (set_evt[i])
    );
  end

endmodule

// File: rtl/dma_req_gate_chk.sv
module dma_req_gate_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_valid,
  input logic [NUM_CH-1:0] req_ready,
  input logic [NUM_CH-1:0] ch_active,
  input logic [NUM_CH-1:0] set_evt
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
    a_r6_valid_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] |-> ch_active[i]);

    a_r7_inactive_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_active[i] |=> !req_valid[i]);

    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !req_ready[i]) |=> (req_valid[i] || !ch_active[i]));

    a_r8_drop_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && !set_evt[i]) |=> !req_valid[i]);

    a_r9_set_beats_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt[i] && ch_active[i]) |=> (req_valid[i] || !ch_active[i]));
  end

endmodule

bind dma_req_gate dma_req_gate_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .ch_active(ch_active),
  .set_evt  (set_evt)
);

// File: tb/dma_req_gate_tb.sv
`timescale 1ns/100ps
module dma_req_gate_tb_top;

  localparam int NC   = 4;
  localparam int NP   = 8;
  localparam int NE   = 2;
  localparam int NSRC = NP + 1 + NE;
  localparam int CW   = $clog2(NC);
  localparam int SW   = $clog2(NSRC);
  localparam int SWC  = NP;  // software source code

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] periph_req = '0;
  logic [NE-1:0] ext_irq = '0;
  logic [NC-1:0] sw_set = '0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_ch = '0;
  logic [1:0]    cfg_mode = '0;
  logic [SW-1:0] cfg_sel = '0;
  logic [NC-1:0] req_valid;
  logic [NC-1:0] req_ready = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_gate #(.NUM_CH(NC), .NUM_PERIPH(NP), .NUM_EXT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ext_irq(ext_irq),
    .sw_set(sw_set), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_mode(cfg_mode),
    .cfg_sel(cfg_sel), .req_valid(req_valid), .req_ready(req_ready)
  );

  task automatic check(input logic [NC-1:0] exp, input string tag);
    checks++;
    if (req_valid !== exp) begin
      errors++;
      $display("FAIL %s: req_valid=%b expected=%b", tag, req_valid, exp);
    end
  endtask

  task automatic cfg_write(input int ch, input int mode, input int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_mode = 2'(mode); cfg_sel = SW'(sel);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Fires source k (for software: channel c) and returns at the first
  // negedge where the request can be observed.
  task automatic fire(input int k, input int c);
    @(negedge clk);
    if (k < NP) begin
      periph_req[k] = 1'b1;
      @(negedge clk);
      periph_req[k] = 1'b0;
    end else if (k == SWC) begin
      sw_set[c] = 1'b1;
      @(negedge clk);
      sw_set[c] = 1'b0;
    end else begin
      ext_irq[k-NP-1] = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic settle(input int k);
    if (k > NP) begin
      ext_irq[k-NP-1] = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check('0, "R1 idle after reset");
    fire(0, 0);             check('0, "R1 default mode off, periph 0");
    fire(SWC, 1);           check('0, "R1 software while off");
    fire(NP + 1, 0); check('0, "R1 external while off"); settle(NP + 1);

    // Sweep: channel x mode x source code x fired trigger (R2 R3 R4 R5 R6)
    for (int c = 0; c < NC; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < (1 << SW); s++) begin
          for (int k = 0; k < NSRC; k++) begin
            logic [NC-1:0] exp;
            cfg_write(c, m, s);
            fire(k, c);
            exp = ((m % 2) == 1 && s == k) ? NC'(1 << c) : '0;
            if (k < NP)        check(exp, "R2 R5 R6 peripheral sweep");
            else if (k == SWC) check(exp, "R4 R5 R6 software sweep");
            else               check(exp, "R3 R5 R6 external sweep");
            settle(k);
            cfg_write(c, 0, s);
          end
        end
      end
    end

    // R3 exact delay: not yet visible after two edges
    cfg_write(3, 1, NP + 2);
    @(negedge clk); ext_irq[1] = 1'b1;
    repeat (2) @(negedge clk); check('0, "R3 not visible after two edges");
    @(negedge clk);            check(4'b1000, "R3 visible after third edge");
    ext_irq[1] = 1'b0;
    req_ready[3] = 1'b1; @(negedge clk); req_ready[3] = 1'b0;
    repeat (3) @(negedge clk); check('0, "R3 falling edge ignored");
    cfg_write(3, 0, 0);

    // R8 back-pressure
    cfg_write(1, 1, SWC);
    fire(SWC, 1); check(4'b0010, "R8 request raised");
    for (int n = 0; n < 5; n++) begin
      @(negedge clk); check(4'b0010, "R8 held without ready");
    end
    req_ready[1] = 1'b1; @(negedge clk); req_ready[1] = 1'b0;
    check('0, "R8 cleared by handshake");

    // R9 set in handshake cycle
    fire(SWC, 1); check(4'b0010, "R9 setup");
    req_ready[1] = 1'b1; sw_set[1] = 1'b1;
    @(negedge clk); sw_set[1] = 1'b0;
    check(4'b0010, "R9 set wins over handshake");
    @(negedge clk); req_ready[1] = 1'b0;
    check('0, "R9 later handshake clears");

    // R10 ready without valid
    req_ready[1] = 1'b1;
    repeat (3) @(negedge clk);
    check('0, "R10 ready alone idle");
    sw_set[1] = 1'b1; @(negedge clk); sw_set[1] = 1'b0; req_ready[1] = 1'b0;
    check(4'b0010, "R10 set not blocked by idle ready");

    // R7 discard in disabled modes
    cfg_write(1, 2, SWC); check('0, "R7 mode 10 drops pending");
    cfg_write(1, 1, SWC); check('0, "R7 dropped request stays gone");
    cfg_write(1, 0, SWC); fire(SWC, 1); check('0, "R7 trigger while off");
    cfg_write(1, 1, SWC); check('0, "R7 trigger while off is lost");

    // R2 held level fires once
    cfg_write(2, 1, 3);
    @(negedge clk); periph_req[3] = 1'b1;
    @(negedge clk); check(4'b0100, "R2 level rise sets");
    req_ready[2] = 1'b1; @(negedge clk); req_ready[2] = 1'b0;
    repeat (3) @(negedge clk); check('0, "R2 held level no retrigger");
    periph_req[3] = 1'b0;

    // R11 isolation and shared source; R6 mode 11 repeats
    cfg_write(0, 3, 5);
    cfg_write(3, 1, 5);
    fire(5, 0); check(4'b1001, "R11 shared source sets both");
    cfg_write(3, 0, 5); check(4'b0001, "R11 write to ch3 leaves ch0");
    req_ready[0] = 1'b1; @(negedge clk); req_ready[0] = 1'b0;
    check('0, "R6 mode 11 handshake");
    fire(5, 0); check(4'b0001, "R6 mode 11 second trigger");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule